// File: doc/BRIEF.md
# Programmable CRC Shift Engine with Indirect Register Window

This block computes CRCs one bit per clock. Each unit keeps a 40-bit residue, a 40-bit feedback polynomial, a 32-bit compare value, a 16-bit input word and a small configuration/status byte. Software programs the polynomial and the starting residue, then writes the input word. A write to the chosen trigger byte of that word starts a run. The run shifts N+1 bits of the word into the residue, least significant bit first. When it ends, a done flag comes up and a compare flag shows whether the residue matches the programmed compare value.

Access goes through three byte ports on one simple byte bus: an address byte, a high data byte and a low data byte. The address byte names a unit and a register-pair index. The high and low data ports then read or write the two halves of that pair. Reads are combinational. A write takes effect at the clock edge where `reg_we` is high. The bus has no data stream and no back-pressure: every write is accepted in the cycle it is presented, so no valid/ready handshake is needed. Software finds out whether a run is active by polling the done flag.

Top module: `crc_window`

## Requirements
- R1: After reset the address byte, input word, residue, polynomial, compare value, shift count and trigger mode are all zero, the compare flag is 0 and the done flag is 1.
- R2: `reg_sel` picks the port: 0 is the address byte, 1 the high data byte, 2 the low data byte, and 3 reads zero. Address bits 7:4 name the unit and bits 3:0 the index. When the unit number is 4 or above, data reads return zero and data writes change nothing. Writes to one unit leave the other units unchanged.
- R3: The index map gives high/low bytes as follows. 0 is input word [15:8]/[7:0]. 1 is output word (read only). 3 is zero/residue[39:32]. 4 is residue[31:24]/[23:16]. 5 is residue[15:8]/[7:0]. 7 is trigger mode/zero. 8 is config-status/polynomial[39:32]. 9 is polynomial[31:24]/[23:16]. 10 is polynomial[15:8]/[7:0]. 11 is compare[31:24]/[23:16]. 12 is compare[15:8]/[7:0]. Every other index reads zero and ignores writes.
- R4: Bit 0 of the trigger mode byte selects which byte starts a run. With 1, a write to input-word byte [15:8] starts it. With 0, a write to byte [7:0] starts it. A write to the other byte only stores the byte.
- R5: With shift count N, a run performs N+1 shifts, one per clock, using input bits 0 through N. If the trigger write is captured at edge E, done reads 0 after edges E through E+N and reads 1 again after edge E+N+1.
- R6: Each shift takes input bit b and forms f = b XOR residue[39]. The residue becomes (residue << 1) XOR (f ? polynomial : 0).
- R7: Writing the config-status byte with bit 6 set, while idle, presets the residue to all ones. Bit 6 always reads 0.
- R8: At the end of a run the compare flag is set if residue[31:0] equals the compare value, and cleared otherwise. Starting a run clears it. Residue bits 39:32 are not compared.
- R9: A trigger-byte write while a run is active is ignored: the run and the stored byte are unchanged.
- R10: The output word reads residue[15:0].
- R11: The config-status byte reads {0, 0, done, compare flag, shift count[3:0]}. Writing it while idle loads the shift count from bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Write strobe for the selected port |
| reg_sel | input | 2 | Port select: 0 address, 1 high data, 2 low data |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Combinational read data of the selected port |

## Verification
A trigger write captured at edge E makes done read 0 from the cycle after E. The residue, the output word and the compare flag are final, and done reads 1, after edge E+N+1. The bench moves the window onto the config-status byte one edge after the trigger. It waits N-1 more edges, samples done as still 0, then samples it as 1 one edge later. Every sample is taken at the falling edge. Trigger-mode and busy-write checks read back state before the next start could overwrite it.

// File: rtl/crc_win_pkg.sv
package crc_win_pkg;
  localparam int RES_W = 40;
  localparam int CMP_W = 32;
  localparam int DIN_W = 16;
  localparam int CNT_W = 4;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_HI   = 2'd1;
  localparam logic [1:0] SEL_LO   = 2'd2;

  localparam logic [3:0] IX_DIN    = 4'h0;
  localparam logic [3:0] IX_DOUT   = 4'h1;
  localparam logic [3:0] IX_RES4   = 4'h3;
  localparam logic [3:0] IX_RES32  = 4'h4;
  localparam logic [3:0] IX_RES10  = 4'h5;
  localparam logic [3:0] IX_MODE   = 4'h7;
  localparam logic [3:0] IX_CFG    = 4'h8;
  localparam logic [3:0] IX_POLY32 = 4'h9;
  localparam logic [3:0] IX_POLY10 = 4'hA;
  localparam logic [3:0] IX_CMP32  = 4'hB;
  localparam logic [3:0] IX_CMP10  = 4'hC;

  localparam int CFG_PRESET_BIT = 6;
endpackage

// File: rtl/crc_addr_dec.sv
module crc_addr_dec
  import crc_win_pkg::*;
#(
  parameter int NUM_UNITS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [1:0]           sel,
  input  logic [7:0]           wdata,
  output logic [7:0]           addr_q,
  output logic [3:0]           idx,
  output logic [NUM_UNITS-1:0] unit_hit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else if (we && sel == SEL_ADDR) addr_q <= wdata;
  end

  assign idx = addr_q[3:0];

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_hit
    assign unit_hit[u] = (addr_q[7:4] == 4'(u));
  end

  // R2
  unit_hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(unit_hit));
endmodule

// File: rtl/crc_unit.sv
module crc_unit
  import crc_win_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit,
  input  logic       we,
  input  logic [1:0] sel,
  input  logic [3:0] idx,
  input  logic [7:0] wdata,
  output logic [7:0] rd_hi,
  output logic [7:0] rd_lo
);
  logic [DIN_W-1:0] din_q;
  logic [RES_W-1:0] res_q, poly_q, res_nxt;
  logic [CMP_W-1:0] cmp_q;
  logic [CNT_W-1:0] cnt_q, step_q;
  logic trig_hi_q, busy_q, done_q, match_q;
  logic wr_hi, wr_lo, trig_wr, start, last, fb, cfg_wr;

  assign wr_hi   = hit && we && sel == SEL_HI;
  assign wr_lo   = hit && we && sel == SEL_LO;
  assign trig_wr = (idx == IX_DIN) && (trig_hi_q ? wr_hi : wr_lo);
  assign start   = trig_wr && !busy_q;
  assign last    = busy_q && (step_q == cnt_q);
  assign cfg_wr  = wr_hi && idx == IX_CFG && !busy_q;

  // one shift step
  assign fb      = din_q[step_q] ^ res_q[RES_W-1];
  assign res_nxt = {res_q[RES_W-2:0], 1'b0} ^ (fb ? poly_q : '0);

  // control: run state, counter, flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; step_q <= '0; done_q <= 1'b1; match_q <= 1'b0;
      cnt_q <= '0; trig_hi_q <= 1'b0;
    end else begin
      if (start) begin
        busy_q <= 1'b1; step_q <= '0; done_q <= 1'b0; match_q <= 1'b0;
      end else if (last) begin
        busy_q <= 1'b0; done_q <= 1'b1;
        match_q <= (res_nxt[CMP_W-1:0] == cmp_q);
      end else if (busy_q) begin
        step_q <= step_q + 1'b1;
      end
      if (cfg_wr) cnt_q <= wdata[CNT_W-1:0];
      if (wr_hi && idx == IX_MODE && !busy_q) trig_hi_q <= wdata[0];
    end
  end

  // data registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_q <= '0; res_q <= '0; poly_q <= '0; cmp_q <= '0;
    end else begin
      if (wr_hi && idx == IX_DIN && !(trig_hi_q && busy_q)) din_q[15:8] <= wdata;
      if (wr_lo && idx == IX_DIN && !(!trig_hi_q && busy_q)) din_q[7:0] <= wdata;
      if (busy_q) res_q <= res_nxt;
      else if (cfg_wr && wdata[CFG_PRESET_BIT]) res_q <= '1;
      else begin
        if (wr_lo && idx == IX_RES4)  res_q[39:32] <= wdata;
        if (wr_hi && idx == IX_RES32) res_q[31:24] <= wdata;
        if (wr_lo && idx == IX_RES32) res_q[23:16] <= wdata;
        if (wr_hi && idx == IX_RES10) res_q[15:8]  <= wdata;
        if (wr_lo && idx == IX_RES10) res_q[7:0]   <= wdata;
      end
      if (wr_lo && idx == IX_CFG)    poly_q[39:32] <= wdata;
      if (wr_hi && idx == IX_POLY32) poly_q[31:24] <= wdata;
      if (wr_lo && idx == IX_POLY32) poly_q[23:16] <= wdata;
      if (wr_hi && idx == IX_POLY10) poly_q[15:8]  <= wdata;
      if (wr_lo && idx == IX_POLY10) poly_q[7:0]   <= wdata;
      if (wr_hi && idx == IX_CMP32)  cmp_q[31:24]  <= wdata;
      if (wr_lo && idx == IX_CMP32)  cmp_q[23:16]  <= wdata;
      if (wr_hi && idx == IX_CMP10)  cmp_q[15:8]   <= wdata;
      if (wr_lo && idx == IX_CMP10)  cmp_q[7:0]    <= wdata;
    end
  end

  // read window
  always_comb begin
    rd_hi = '0;
    rd_lo = '0;
    case (idx)
      IX_DIN:    begin rd_hi = din_q[15:8];  rd_lo = din_q[7:0];  end
      IX_DOUT:   begin rd_hi = res_q[15:8];  rd_lo = res_q[7:0];  end
      IX_RES4:   rd_lo = res_q[39:32];
      IX_RES32:  begin rd_hi = res_q[31:24]; rd_lo = res_q[23:16]; end
      IX_RES10:  begin rd_hi = res_q[15:8];  rd_lo = res_q[7:0];  end
      IX_MODE:   rd_hi = {7'b0, trig_hi_q};
      IX_CFG:    begin rd_hi = {2'b00, done_q, match_q, cnt_q}; rd_lo = poly_q[39:32]; end
      IX_POLY32: begin rd_hi = poly_q[31:24]; rd_lo = poly_q[23:16]; end
      IX_POLY10: begin rd_hi = poly_q[15:8];  rd_lo = poly_q[7:0];  end
      IX_CMP32:  begin rd_hi = cmp_q[31:24];  rd_lo = cmp_q[23:16];  end
      IX_CMP10:  begin rd_hi = cmp_q[15:8];   rd_lo = cmp_q[7:0];   end
      default:   ;
    endcase
  end

  // R5
  start_drops_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done_q && busy_q));
  // R5
  run_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(step_q) == $past(cnt_q));
  // R7
  preset_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && wdata[CFG_PRESET_BIT]) |=> (res_q == '1));
  // R8
  match_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done_q) && $stable(cmp_q)) |-> (match_q == (res_q[CMP_W-1:0] == cmp_q)));
  // R9
  busy_trig_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last && trig_wr) |=> ($stable(din_q) && busy_q));
  // R11
  always_comb begin
    if (rst_n && idx == IX_CFG) cfg_bit6_zero_chk: assert (rd_hi[CFG_PRESET_BIT] == 1'b0);
  end
endmodule

// File: rtl/crc_window.sv
module crc_window
  import crc_win_pkg::*;
#(
  parameter int NUM_UNITS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [1:0] reg_sel,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata
);
  logic [7:0]           addr_q;
  logic [3:0]           idx;
  logic [NUM_UNITS-1:0] unit_hit;
  logic [7:0]           hi_b [NUM_UNITS];
  logic [7:0]           lo_b [NUM_UNITS];
  logic [7:0]           hi_m, lo_m;

  crc_addr_dec #(.NUM_UNITS(NUM_UNITS)) u_dec (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .addr_q(addr_q), .idx(idx), .unit_hit(unit_hit)
  );

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    crc_unit u_unit (
      .clk(clk), .rst_n(rst_n), .hit(unit_hit[u]), .we(reg_we), .sel(reg_sel),
      .idx(idx), .wdata(reg_wdata), .rd_hi(hi_b[u]), .rd_lo(lo_b[u])
    );
  end

  always_comb begin
    hi_m = '0;
    lo_m = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (unit_hit[u]) begin
        hi_m = hi_m | hi_b[u];
        lo_m = lo_m | lo_b[u];
      end
    end
    case (reg_sel)
      SEL_ADDR: reg_rdata = addr_q;
      SEL_HI:   reg_rdata = hi_m;
      SEL_LO:   reg_rdata = lo_m;
      default:  reg_rdata = '0;
    endcase
  end

  // R2
  bad_unit_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(addr_q[7:4]) >= NUM_UNITS && reg_sel != SEL_ADDR) |-> (reg_rdata == 8'h00));
endmodule

// File: tb/crc_window_bench.sv
module crc_window_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;

  int checks = 0;
  int errors = 0;
  bit pend = 1'b0;
  bit finished = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  crc_window u_crc_window (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  function automatic logic [39:0] model(input logic [39:0] r, input logic [39:0] p,
                                        input logic [15:0] d, input int n);
    for (int i = 0; i <= n; i++) begin
      logic f;
      f = d[i] ^ r[39];
      r = {r[38:0], 1'b0} ^ (f ? p : 40'h0);
    end
    return r;
  endfunction

  // monitor: pops expected bytes and compares at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (pend) begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (reg_rdata !== e) begin
          errors++;
          $display("FAIL %s actual %02h expected %02h", t, reg_rdata, e);
        end
        pend = 1'b0;
      end
    end
  end

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(posedge clk); #2;
    reg_we = 1'b0;
  endtask

  task automatic chk(input logic [1:0] s, input logic [7:0] e, input string t);
    reg_sel = s;
    exp_q.push_back(e);
    tag_q.push_back(t);
    pend = 1'b1;
    wait (pend == 1'b0);
  endtask

  task automatic chk_reg(input logic [3:0] unit, input logic [3:0] ix, input bit hi,
                         input logic [7:0] e, input string t);
    wr(2'd0, {unit, ix});
    chk(hi ? 2'd1 : 2'd2, e, t);
  endtask

  task automatic chk_res(input logic [3:0] unit, input logic [39:0] e, input string t);
    chk_reg(unit, 4'h3, 1'b0, e[39:32], t);
    chk_reg(unit, 4'h4, 1'b1, e[31:24], t);
    chk_reg(unit, 4'h4, 1'b0, e[23:16], t);
    chk_reg(unit, 4'h5, 1'b1, e[15:8], t);
    chk_reg(unit, 4'h5, 1'b0, e[7:0], t);
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  localparam logic [39:0] POLY = 40'h1A_0000_8005;
  logic [39:0] exp_a, exp_b, exp_c;
  bit m_b;

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(posedge clk); #2;

    // R1 reset state
    chk(2'd0, 8'h00, "R1 address byte");
    chk_reg(4'h0, 4'h8, 1'b1, 8'h20, "R1 R11 config-status after reset");
    chk_res(4'h0, 40'h0, "R1 residue after reset");

    // program polynomial and compare
    wr(2'd0, 8'h08); wr(2'd2, POLY[39:32]);
    wr(2'd0, 8'h09); wr(2'd1, POLY[31:24]); wr(2'd2, POLY[23:16]);
    wr(2'd0, 8'h0A); wr(2'd1, POLY[15:8]);  wr(2'd2, POLY[7:0]);
    chk(2'd1, POLY[15:8], "R3 polynomial byte 1");
    exp_a = model(40'hFF_FFFF_FFFF, POLY, 16'h005C, 7);
    wr(2'd0, 8'h0B); wr(2'd1, exp_a[31:24]); wr(2'd2, exp_a[23:16]);
    wr(2'd0, 8'h0C); wr(2'd1, exp_a[15:8]);  wr(2'd2, exp_a[7:0]);

    // R7 preset + shift count 7
    wr(2'd0, 8'h08); wr(2'd1, 8'h47);
    chk(2'd1, 8'h27, "R7 R11 set-residue bit reads zero");
    chk_res(4'h0, 40'hFF_FFFF_FFFF, "R7 residue preset to ones");

    // op A: low-byte trigger, N=7, with done timing
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h5C);           // trigger edge E
    wr(2'd0, 8'h08);           // edge E+1
    repeat (6) @(posedge clk); // edge E+7
    #2;
    chk(2'd1, 8'h07, "R5 done still low after edge E+N");
    @(posedge clk); #2;        // edge E+8
    chk(2'd1, 8'h37, "R5 R8 done and match after edge E+N+1");
    chk_res(4'h0, exp_a, "R6 residue after 8-bit run");
    chk_reg(4'h0, 4'h1, 1'b1, exp_a[15:8], "R10 output word high");
    chk_reg(4'h0, 4'h1, 1'b0, exp_a[7:0], "R10 output word low");

    // op B: N=15, no preset, busy write to trigger byte ignored
    wr(2'd0, 8'h08); wr(2'd1, 8'h0F);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h3C);
    wr(2'd2, 8'h96);           // trigger
    wr(2'd2, 8'hFF);           // during run, must be ignored
    chk(2'd2, 8'h96, "R9 trigger byte unchanged during run");
    repeat (20) @(posedge clk); #2;
    exp_b = model(exp_a, POLY, 16'h3C96, 15);
    m_b = (exp_b[31:0] == exp_a[31:0]);
    chk_res(4'h0, exp_b, "R6 R9 residue after 16-bit run");
    chk_reg(4'h0, 4'h8, 1'b1, {2'b00, 1'b1, m_b, 4'hF}, "R8 compare flag after mismatch run");

    // op C: high-byte trigger
    wr(2'd0, 8'h07); wr(2'd1, 8'h01);
    chk(2'd1, 8'h01, "R4 trigger mode readback");
    wr(2'd0, 8'h08); wr(2'd1, 8'h43);
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h0A);           // low byte: no start in high mode
    wr(2'd0, 8'h08);
    chk(2'd1, {2'b00, 1'b1, m_b, 4'h3}, "R4 low byte does not start in high mode");
    chk_res(4'h0, 40'hFF_FFFF_FFFF, "R4 residue untouched by low-byte write");
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h77);           // high byte starts
    repeat (10) @(posedge clk); #2;
    exp_c = model(40'hFF_FFFF_FFFF, POLY, 16'h770A, 3);
    chk_res(4'h0, exp_c, "R4 R6 residue after high-byte triggered run");

    // R2 invalid unit, other unit isolation, unassigned index
    wr(2'd0, 8'h53); wr(2'd2, 8'hAA);
    chk(2'd2, 8'h00, "R2 invalid unit reads zero");
    chk(2'd0, 8'h53, "R2 address byte readback");
    chk_res(4'h1, 40'h0, "R2 unit 1 untouched");
    chk_reg(4'h0, 4'h2, 1'b1, 8'h00, "R3 unassigned index reads zero");
    wr(2'd2, 8'h55);
    chk(2'd2, 8'h00, "R3 unassigned index ignores writes");
    chk(2'd3, 8'h00, "R2 select 3 reads zero");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule